// File: doc/BRIEF.md
# Channel Command and State Controller

This block controls activation for one channel of a copy, XOR, checksum or fill engine. A simple register port writes command bits (start, stop, pause, restart). The port also writes the channel configuration, the operation mode and the next-descriptor pointer. Reads return the channel state, the sticky error flags and the stored registers. The block drives a run enable, the selected operation mode, the configuration word and the descriptor pointer to a separate datapath. That datapath sends back a one-cycle done pulse when its work is finished.

Each command is accepted only in the states where it makes sense. A start is also refused when the descriptor pointer is zero or misaligned for the current mode. A general configuration write never alters the operation mode. The mode changes only through its own register.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: The state reads back in bits [1:0] at address 3, encoded idle = 0, active = 1, paused = 2. After reset the state is idle and `runEn` is low. `runEn` is high exactly while the state is active.
- R2: A command is a write to address 3, with start = bit 0, stop = bit 1, pause = bit 2 and restart = bit 3. A start while idle with an acceptable pointer moves the state to active on the next clock edge.
- R3: A pause while active moves the state to paused. A restart while paused moves it back to active. A stop while active moves it to idle.
- R4: A stop while idle changes neither the state nor any error flag.
- R5: An illegal command has no effect on the state and sets the illegal flag (error bit 0). Illegal commands are: pause, restart or start while paused or idle, where not permitted above; a restart while active; a stop or pause while paused; and any write with more than one command bit set. A write with no command bit set does nothing.
- R6: A start while active leaves the channel active and sets the busy flag (error bit 1).
- R7: A start while idle is refused when the pointer is unacceptable. The state stays idle and the bad-pointer flag (error bit 2) is set. A zero pointer is always unacceptable. In XOR mode bits [5:0] must be zero. In CRC and DMA modes bits [4:0] must be zero. Fill mode needs only a nonzero pointer.
- R8: A write to address 0 updates only the protect bit [4], source burst [10:8] and destination burst [14:12]. The mode is kept. A write to address 1 sets the mode from bits [1:0] (XOR = 0, CRC = 1, DMA = 2, fill = 3), and `modeOut` follows it.
- R9: After reset the configuration word reads 0x4410: mode XOR, protect set, both burst limits 4.
- R10: A done pulse while active returns the state to idle. A done pulse while idle or paused is ignored.
- R11: The error flags read at address 4 are sticky. Writing ones to address 4 clears exactly those flags. The descriptor pointer is written and read at address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Combinational read data |
| doneIn | input | 1 | Completion pulse from the datapath |
| runEn | output | 1 | Datapath run enable |
| modeOut | output | 2 | Selected operation mode |
| cfgOut | output | DATA_W | Configuration word |
| descPtrOut | output | DATA_W | Next-descriptor pointer |

## Verification
Every write and every done pulse takes effect at the clock edge where it is sampled. The new state, flags, configuration and outputs are therefore all visible one edge after the stimulus. The bench drives stimulus on the falling edge and holds it for one full period. It then reads every result through the combinational read port on the next falling edge, which is exactly one register stage later. The reference model is updated at the same point, so each comparison matches one stimulus to its one-cycle result.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2
  } chanState_e;

  typedef enum logic [1:0] {
    MD_XOR  = 2'd0,
    MD_CRC  = 2'd1,
    MD_DMA  = 2'd2,
    MD_FILL = 2'd3
  } opMode_e;

  // register addresses
  localparam int A_CFG  = 0;
  localparam int A_MODE = 1;
  localparam int A_PTR  = 2;
  localparam int A_CMD  = 3;
  localparam int A_ERR  = 4;

  // command bit positions
  localparam int CB_START   = 0;
  localparam int CB_STOP    = 1;
  localparam int CB_PAUSE   = 2;
  localparam int CB_RESTART = 3;
  localparam int CMD_W      = 4;

  // error flag positions
  localparam int EB_ILLEGAL = 0;
  localparam int EB_BUSY    = 1;
  localparam int EB_BADPTR  = 2;
  localparam int ERR_W      = 3;

  // configuration field positions
  localparam int CF_MODE_LO = 0;
  localparam int CF_PROT    = 4;
  localparam int CF_SRC_LO  = 8;
  localparam int CF_DST_LO  = 12;
  localparam int BURST_W    = 3;

  typedef struct packed {
    logic cfgWr;
    logic modeWr;
    logic ptrWr;
  } regStrobe_t;
endpackage

// File: rtl/chanctl_regs.sv
module chanctl_regs
  import chanctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int XOR_ALIGN = 6,
  parameter int BLK_ALIGN = 5,
  parameter int BURST_DEF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  chanState_e        stateIn,
  input  logic [ERR_W-1:0]  errIn,
  output logic [DATA_W-1:0] rdData,
  output opMode_e           modeOut,
  output logic [DATA_W-1:0] cfgOut,
  output logic [DATA_W-1:0] ptrOut,
  output logic              ptrOk
);
  localparam logic [BURST_W-1:0] BURST_RST = BURST_W'(BURST_DEF);

  opMode_e            modeQ;
  logic               protectQ;
  logic [BURST_W-1:0] srcBurstQ;
  logic [BURST_W-1:0] dstBurstQ;
  logic [DATA_W-1:0]  ptrQ;
  logic [DATA_W-1:0]  cfgWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MD_XOR;
      protectQ  <= 1'b1;
      srcBurstQ <= BURST_RST;
      dstBurstQ <= BURST_RST;
      ptrQ      <= '0;
    end else begin
      if (strobe.cfgWr) begin
        protectQ  <= wrData[CF_PROT];
        srcBurstQ <= wrData[CF_SRC_LO +: BURST_W];
        dstBurstQ <= wrData[CF_DST_LO +: BURST_W];
      end
      if (strobe.modeWr) modeQ <= opMode_e'(wrData[CF_MODE_LO +: 2]);
      if (strobe.ptrWr)  ptrQ  <= wrData;
    end
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[CF_MODE_LO +: 2]       = modeQ;
    cfgWord[CF_PROT]               = protectQ;
    cfgWord[CF_SRC_LO +: BURST_W]  = srcBurstQ;
    cfgWord[CF_DST_LO +: BURST_W]  = dstBurstQ;
  end

  always_comb begin
    ptrOk = 1'b0;
    if (ptrQ != '0) begin
      unique case (modeQ)
        MD_XOR:         ptrOk = (ptrQ[XOR_ALIGN-1:0] == '0);
        MD_CRC, MD_DMA: ptrOk = (ptrQ[BLK_ALIGN-1:0] == '0);
        default:        ptrOk = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (rdAddr == ADDR_W'(A_CFG) || rdAddr == ADDR_W'(A_MODE)) rdData = cfgWord;
    else if (rdAddr == ADDR_W'(A_PTR)) rdData = ptrQ;
    else if (rdAddr == ADDR_W'(A_CMD)) rdData = DATA_W'(stateIn);
    else if (rdAddr == ADDR_W'(A_ERR)) rdData = DATA_W'(errIn);
    else rdData = '0;
  end

  assign modeOut = modeQ;
  assign cfgOut  = cfgWord;
  assign ptrOut  = ptrQ;

  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.modeWr) |=> (modeQ == $past(modeQ)));  // R8
  AST_ZERO_PTR_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (ptrOut == '0) |-> !ptrOk);  // R7
endmodule

// File: rtl/chanctl_ctrl.sv
module chanctl_ctrl
  import chanctl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              doneIn,
  input  logic              ptrOk,
  output regStrobe_t        strobe,
  output chanState_e        stateOut,
  output logic [ERR_W-1:0]  errOut
);
  chanState_e       stateQ, stateD;
  logic [ERR_W-1:0] errQ, errSet, errClr;
  logic             cmdWr;

  assign cmdWr         = wrEn && (wrAddr == ADDR_W'(A_CMD));
  assign strobe.cfgWr  = wrEn && (wrAddr == ADDR_W'(A_CFG));
  assign strobe.modeWr = wrEn && (wrAddr == ADDR_W'(A_MODE));
  assign strobe.ptrWr  = wrEn && (wrAddr == ADDR_W'(A_PTR));
  assign errClr = (wrEn && (wrAddr == ADDR_W'(A_ERR))) ? cmdData[ERR_W-1:0] : '0;

  always_comb begin
    stateD = stateQ;
    errSet = '0;
    if (cmdWr && cmdData != '0) begin
      if ($countones(cmdData) != 1) begin
        errSet[EB_ILLEGAL] = 1'b1;
      end else if (cmdData[CB_START]) begin
        case (stateQ)
          ST_IDLE:   if (ptrOk) stateD = ST_ACTIVE; else errSet[EB_BADPTR] = 1'b1;
          ST_ACTIVE: errSet[EB_BUSY] = 1'b1;
          default:   errSet[EB_ILLEGAL] = 1'b1;
        endcase
      end else if (cmdData[CB_STOP]) begin
        case (stateQ)
          ST_ACTIVE: stateD = ST_IDLE;
          ST_IDLE:   stateD = ST_IDLE;
          default:   errSet[EB_ILLEGAL] = 1'b1;
        endcase
      end else if (cmdData[CB_PAUSE]) begin
        if (stateQ == ST_ACTIVE) stateD = ST_PAUSED;
        else errSet[EB_ILLEGAL] = 1'b1;
      end else begin
        if (stateQ == ST_PAUSED) stateD = ST_ACTIVE;
        else errSet[EB_ILLEGAL] = 1'b1;
      end
    end
    if (doneIn && stateQ == ST_ACTIVE && stateD == ST_ACTIVE) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= '0;
    end else begin
      stateQ <= stateD;
      errQ   <= (errQ & ~errClr) | errSet;
    end
  end

  assign stateOut = stateQ;
  assign errOut   = errQ;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 2'd3);  // R1
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == 4'b0001 && stateQ == ST_IDLE && !ptrOk)
      |=> (stateQ == ST_IDLE && errQ[EB_BADPTR]));  // R7
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PAUSED && $past(stateQ) != ST_PAUSED)
      |-> ($past(stateQ) == ST_ACTIVE && $past(cmdWr)));  // R3
  AST_IDLE_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == 4'b0010 && stateQ == ST_IDLE)
      |=> (stateQ == ST_IDLE && errQ == $past(errQ)));  // R4
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && stateQ == ST_ACTIVE && !cmdWr) |=> (stateQ == ST_IDLE));  // R10
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errQ[EB_ILLEGAL] && !(wrEn && wrAddr == ADDR_W'(A_ERR) && cmdData[EB_ILLEGAL]))
      |=> errQ[EB_ILLEGAL]);  // R11
  AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == 4'b0001 && stateQ == ST_ACTIVE)
      |=> (stateQ == ST_ACTIVE && errQ[EB_BUSY]));  // R6
endmodule

// File: rtl/chan_cmd_ctrl.sv
module chan_cmd_ctrl
  import chanctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int XOR_ALIGN = 6,
  parameter int BLK_ALIGN = 5,
  parameter int BURST_DEF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              doneIn,
  output logic              runEn,
  output logic [1:0]        modeOut,
  output logic [DATA_W-1:0] cfgOut,
  output logic [DATA_W-1:0] descPtrOut
);
  regStrobe_t       strobe;
  chanState_e       state;
  logic [ERR_W-1:0] errFlags;
  logic             ptrOk;
  opMode_e          mode;

  chanctl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cmdData(wrData[CMD_W-1:0]), .doneIn(doneIn), .ptrOk(ptrOk),
    .strobe(strobe), .stateOut(state), .errOut(errFlags)
  );

  chanctl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .XOR_ALIGN(XOR_ALIGN),
    .BLK_ALIGN(BLK_ALIGN), .BURST_DEF(BURST_DEF)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .stateIn(state), .errIn(errFlags), .rdData(rdData),
    .modeOut(mode), .cfgOut(cfgOut), .ptrOut(descPtrOut), .ptrOk(ptrOk)
  );

  assign runEn   = (state == ST_ACTIVE);
  assign modeOut = mode;
endmodule

// File: tb/tb_chan_cmd_ctrl.sv
module tb_chan_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        doneIn = 1'b0;
  logic        runEn;
  logic [1:0]  modeOut;
  logic [31:0] cfgOut, descPtrOut;

  chan_cmd_ctrl dut (.*);

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // reference model
  int          mState;
  int          mMode;
  logic        mProt;
  logic [2:0]  mSrc, mDst;
  logic [31:0] mPtr;
  logic [2:0]  mErr;

  function automatic logic [31:0] expCfg();
    logic [31:0] w = '0;
    w[1:0] = 2'(mMode); w[4] = mProt; w[10:8] = mSrc; w[14:12] = mDst;
    return w;
  endfunction

  function automatic bit ptrGood();
    if (mPtr == 0) return 0;
    if (mMode == 0) return mPtr[5:0] == 0;
    if (mMode == 3) return 1;
    return mPtr[4:0] == 0;
  endfunction

  task automatic applyCmd(input logic [3:0] b);
    int n = 0;
    for (int i = 0; i < 4; i++) if (b[i]) n++;
    if (n == 0) return;
    if (n > 1) begin mErr[0] = 1; return; end
    if (b[0]) begin
      if (mState == 0) begin if (ptrGood()) mState = 1; else mErr[2] = 1; end
      else if (mState == 1) mErr[1] = 1;
      else mErr[0] = 1;
    end else if (b[1]) begin
      if (mState == 1) mState = 0; else if (mState == 2) mErr[0] = 1;
    end else if (b[2]) begin
      if (mState == 1) mState = 2; else mErr[0] = 1;
    end else begin
      if (mState == 2) mState = 1; else mErr[0] = 1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rdAddr = 3'(a); #1; v = rdData;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(3, v); chk(tag, v, 32'(mState));
    rd(4, v); chk(tag, v, 32'(mErr));
    rd(0, v); chk(tag, v, expCfg());
    rd(2, v); chk(tag, v, mPtr);
    chk(tag, {31'b0, runEn}, {31'b0, mState == 1});
    chk(tag, {30'b0, modeOut}, 32'(mMode));
    chk(tag, cfgOut, expCfg());
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = 3'(a); wrData = d;
    @(negedge clk); wrEn = 0;
    case (a)
      0: begin mProt = d[4]; mSrc = d[10:8]; mDst = d[14:12]; end
      1: mMode = int'(d[1:0]);
      2: mPtr = d;
      3: applyCmd(d[3:0]);
      4: mErr = mErr & ~d[2:0];
      default: ;
    endcase
  endtask

  task automatic done();
    @(negedge clk); doneIn = 1;
    @(negedge clk); doneIn = 0;
    if (mState == 1) mState = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    mState = 0; mMode = 0; mProt = 1; mSrc = 3'd4; mDst = 3'd4; mPtr = 0; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1_R9_reset");
    rd(0, r); chk("R9", r, 32'h0000_4410);

    // R7: zero pointer, then misaligned for XOR, then good under DMA
    wr(3, 32'h1); checkAll("R7_zero_ptr");
    wr(2, 32'h0000_1020); wr(3, 32'h1); checkAll("R7_xor_align");
    wr(4, 32'h4); checkAll("R11_clear");
    wr(1, 32'h2); wr(3, 32'h1); checkAll("R2_R7_dma_start");
    // R6 busy
    wr(3, 32'h1); checkAll("R6_busy");
    // R3 pause/restart/stop
    wr(3, 32'h4); checkAll("R3_pause");
    wr(3, 32'h2); checkAll("R5_stop_paused");
    wr(3, 32'h1); checkAll("R5_start_paused");
    wr(3, 32'h8); checkAll("R3_restart");
    wr(3, 32'h8); checkAll("R5_restart_active");
    wr(3, 32'h2); checkAll("R3_stop");
    wr(4, 32'h1); checkAll("R11_partial_clear");
    wr(3, 32'h2); checkAll("R4_idle_stop");
    wr(3, 32'h6); checkAll("R5_multi_bits");
    wr(3, 32'h0); checkAll("R5_empty");
    // R8 config write with mode bits set keeps mode
    wr(0, 32'h0000_7513); checkAll("R8_cfg_keeps_mode");
    wr(1, 32'h3); checkAll("R8_mode_fill");
    // R10 done
    wr(3, 32'h1); done(); checkAll("R10_done_active");
    done(); checkAll("R10_done_idle");
    wr(3, 32'h1); wr(3, 32'h4); done(); checkAll("R10_done_paused");
    wr(3, 32'h8); wr(3, 32'h2); wr(4, 32'h7); checkAll("R11_clear_all");

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 9));
      logic [31:0] d = $urandom;
      case (op)
        0: begin wr(0, d); checkAll("R8_rand_cfg"); end
        1: begin wr(1, d); checkAll("R8_rand_mode"); end
        2: begin
             case ($urandom_range(0, 3))
               0: d = 0;
               1: d = d & ~32'h3f;
               2: d = d & ~32'h1f;
               default: ;
             endcase
             wr(2, d); checkAll("R7_rand_ptr");
           end
        3, 4, 5, 6: begin
             if ($urandom_range(0, 7) == 0) d = d & 32'hf;
             else d = 32'h1 << $urandom_range(0, 3);
             wr(3, d); checkAll("R2_R5_rand_cmd");
           end
        7: begin done(); checkAll("R10_rand_done"); end
        default: begin wr(4, d); checkAll("R11_rand_clear"); end
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule